// File: doc/BRIEF.md
# Registered Command/Address Buffer with Select Gating

This block is a clocked staging register for memory command and address lines. It sits between a memory controller and a row of DRAM devices. On each rising clock edge it captures a data word and presents it on registered outputs. The block has two layouts. In the wide layout, 25 inputs map one-to-one onto 25 outputs. In the paired layouts, 14 inputs are each driven onto two output banks, A and B. Two static strap pins choose the layout, and the block latches them only while reset is low. Output positions that the chosen layout does not use are driven low.

Two active-low select inputs gate the data outputs. When both selects are high, the data outputs keep their values. When either select is low, the outputs load on every edge. Tying the second select low therefore turns the block into a plain register. The clock-enable, termination and first-select lines are registered on every edge and are never gated.

The parity bit for a word arrives one clock after that word. The block compares it with the even parity of the bits it captured and places the result on a registered parity output. A mismatch pulls an active-low error flag low for two clocks. A small state machine tracks whether a parity check is due:
- It is in `PAR_IDLE` when nothing is pending.
- It moves to `PAR_PEND` on a gated-open edge.
- It goes back to `PAR_IDLE` on a gated-closed edge.

A second machine drives the error flag:
- From `ERR_CLEAR` it moves to `ERR_FLAG` on a mismatch.
- It stays in `ERR_FLAG` while its hold counter runs down, and reloads the counter on a fresh mismatch.
- It returns to `ERR_CLEAR` when the counter reaches zero.

The active-low reset is asynchronous. It clears every register and pulls every output low at once.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: In the wide layout (`cfg_pair`=0), a word on `d` with a select low appears on `q_a[24:0]` after the next rising edge.
- R2: When `sel_a_n` and `sel_b_n` are both high at an edge, `q_a` and `q_b` keep their previous values.
- R3: When either select is low at an edge, the data outputs load. This includes `sel_b_n` held low while `sel_a_n` is high.
- R4: `cke_q`, `odt_q` and `cs_q_n` take the values of `cke_d`, `odt_d` and `sel_a_n` at every edge, whatever the gating.
- R5: While `rst_n` is low, every output (including `err_n`) is low. Entry into reset takes effect without a clock edge.
- R6: The first rising edge after `rst_n` rises captures the inputs.
- R7: Paired layout A (`cfg_pair`=1, `cfg_alt`=0) drives `d[13:0]` onto both `q_a[13:0]` and `q_b[13:0]`.
- R8: Paired layout B (`cfg_pair`=1, `cfg_alt`=1) drives `d[24:11]` onto both `q_a[13:0]` and `q_b[13:0]`.
- R9: The block samples `cfg_pair` and `cfg_alt` only while reset is low. A change while running leaves the layout unchanged.
- R10: After an edge that follows a gated-open capture, `par_q` equals `par_d` XOR the even parity of the active bits captured at that earlier edge. A value of 1 means mismatch.
- R11: A mismatch holds `err_n` low for exactly two edges, unless a new mismatch reloads the hold.
- R12: After a gated-closed edge, the next edge performs no check: `par_q` holds and no error is raised.
- R13: Unused positions are low: `q_b` in the wide layout, and `q_a[24:14]` in the paired layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, also the strap sampling window |
| d | input | 25 | Data word |
| sel_a_n | input | 1 | First active-low select, also registered to `cs_q_n` |
| sel_b_n | input | 1 | Second active-low select |
| cke_d | input | 1 | Clock-enable line, never gated |
| odt_d | input | 1 | Termination line, never gated |
| par_d | input | 1 | Parity for the word captured one edge earlier |
| cfg_pair | input | 1 | Strap: 0 wide layout, 1 paired layout |
| cfg_alt | input | 1 | Strap: paired variant, 0 layout A, 1 layout B |
| q_a | output | 25 | Data output bank A (all positions in wide layout) |
| q_b | output | 14 | Data output bank B (paired copy) |
| cke_q | output | 1 | Registered clock-enable |
| odt_q | output | 1 | Registered termination |
| cs_q_n | output | 1 | Registered first select |
| par_q | output | 1 | Parity check result, 1 on mismatch |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench closes the gate while it toggles the control lines and feeds wrong parity. A design that gated the control lines, or that checked parity after a closed edge, would show a changed `cke_q` or a spurious error. It changes the straps mid-run and expects the old layout. A design that decoded the live pins would remap the outputs. It asserts reset half-way through a cycle and reads the outputs before any edge, so a synchronous clear is caught. It also drives data on the very first edge after release, which catches a design that needs a warm-up edge.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    localparam int WIDE_W = 25;
    localparam int PAIR_W = 14;

    typedef enum logic [1:0] {
        LAY_WIDE   = 2'd0,
        LAY_PAIR_A = 2'd1,
        LAY_PAIR_B = 2'd2
    } layout_e;

    typedef enum logic {
        PAR_IDLE = 1'b0,
        PAR_PEND = 1'b1
    } par_state_e;

    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_FLAG  = 1'b1
    } err_state_e;

    function automatic layout_e decode_straps(input logic pair, input logic alt);
        if (!pair)
            return LAY_WIDE;
        else if (alt)
            return LAY_PAIR_B;
        else
            return LAY_PAIR_A;
    endfunction

endpackage

// File: rtl/rb_strap_latch.sv
module rb_strap_latch
    import regbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_pair,
    input  logic    cfg_alt,
    output layout_e layout
);

    // Straps load only while reset is held; afterwards the layout is frozen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            layout <= decode_straps(cfg_pair, cfg_alt);
        else
            layout <= layout;
    end

    AST_LAYOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) || $stable(layout) || !$past(rst_n)) // R9
        else $error("layout changed while running");

endmodule

// File: rtl/rb_lane_map.sv
module rb_lane_map
    import regbuf_pkg::*;
#(
    parameter int W_WIDE = WIDE_W,
    parameter int W_PAIR = PAIR_W
) (
    input  layout_e           layout,
    input  logic [W_WIDE-1:0] d,
    output logic [W_WIDE-1:0] map_a,
    output logic [W_PAIR-1:0] map_b
);

    localparam int B_BASE = W_WIDE - W_PAIR;

    logic [W_WIDE-1:0] wide_v;
    logic [W_PAIR-1:0] low_v;
    logic [W_PAIR-1:0] high_v;

    generate
        for (genvar i = 0; i < W_WIDE; i++) begin : g_wide
            assign wide_v[i] = d[i];
        end
        for (genvar j = 0; j < W_PAIR; j++) begin : g_pair
            assign low_v[j]  = d[j];
            assign high_v[j] = d[B_BASE + j];
        end
    endgenerate

    always_comb begin
        map_a = '0;
        map_b = '0;
        unique case (layout)
            LAY_WIDE: begin
                map_a = wide_v;
            end
            LAY_PAIR_A: begin
                map_a[W_PAIR-1:0] = low_v;
                map_b             = low_v;
            end
            LAY_PAIR_B: begin
                map_a[W_PAIR-1:0] = high_v;
                map_b             = high_v;
            end
            default: begin
                map_a = '0;
                map_b = '0;
            end
        endcase
    end

    always_comb begin
        if (layout != LAY_WIDE)
            AST_PAIR_UPPER_LOW: assert (map_a[W_WIDE-1:W_PAIR] == '0) // R13
                else $error("upper positions driven in paired layout");
        else
            AST_WIDE_B_LOW: assert (map_b == '0) // R13
                else $error("bank B driven in wide layout");
    end

endmodule

// File: rtl/rb_parity_chk.sv
module rb_parity_chk
    import regbuf_pkg::*;
#(
    parameter int ERR_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic cap_par,
    input  logic par_d,
    output logic par_q,
    output logic err_n
);

    localparam int CW = (ERR_HOLD < 2) ? 1 : $clog2(ERR_HOLD);

    par_state_e       pstate;
    par_state_e       pstate_nx;
    err_state_e       estate;
    err_state_e       estate_nx;
    logic             held_par;
    logic [CW-1:0]    hold_cnt;
    logic [CW-1:0]    hold_cnt_nx;
    logic             mismatch;
    logic             hit;

    assign mismatch = held_par ^ par_d;
    assign hit      = (pstate == PAR_PEND) && mismatch;

    // check-due machine
    always_comb begin
        pstate_nx = pstate;
        unique case (pstate)
            PAR_IDLE: pstate_nx = cap_en ? PAR_PEND : PAR_IDLE;
            PAR_PEND: pstate_nx = cap_en ? PAR_PEND : PAR_IDLE;
            default:  pstate_nx = PAR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pstate   <= PAR_IDLE;
            held_par <= 1'b0;
            par_q    <= 1'b0;
        end else begin
            pstate <= pstate_nx;
            if (cap_en)
                held_par <= cap_par;
            if (pstate == PAR_PEND)
                par_q <= mismatch;
        end
    end

    // error-hold machine
    always_comb begin
        estate_nx   = estate;
        hold_cnt_nx = hold_cnt;
        unique case (estate)
            ERR_CLEAR: begin
                if (hit) begin
                    estate_nx   = ERR_FLAG;
                    hold_cnt_nx = CW'(ERR_HOLD - 1);
                end
            end
            ERR_FLAG: begin
                if (hit)
                    hold_cnt_nx = CW'(ERR_HOLD - 1);
                else if (hold_cnt == '0)
                    estate_nx = ERR_CLEAR;
                else
                    hold_cnt_nx = hold_cnt - 1'b1;
            end
            default: estate_nx = ERR_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            estate   <= ERR_CLEAR;
            hold_cnt <= '0;
        end else begin
            estate   <= estate_nx;
            hold_cnt <= hold_cnt_nx;
        end
    end

    assign err_n = rst_n && (estate == ERR_CLEAR);

    AST_ERR_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n) // R11
        else $error("error flag shorter than two clocks");

    AST_PPO_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PAR_IDLE) |=> $stable(par_q)) // R12
        else $error("parity result moved without a pending check");

    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PAR_IDLE && estate == ERR_CLEAR) |=> err_n) // R12
        else $error("error raised without a check");

endmodule

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf
    import regbuf_pkg::*;
#(
    parameter int W_WIDE   = WIDE_W,
    parameter int W_PAIR   = PAIR_W,
    parameter int ERR_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W_WIDE-1:0] d,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              cke_d,
    input  logic              odt_d,
    input  logic              par_d,
    input  logic              cfg_pair,
    input  logic              cfg_alt,
    output logic [W_WIDE-1:0] q_a,
    output logic [W_PAIR-1:0] q_b,
    output logic              cke_q,
    output logic              odt_q,
    output logic              cs_q_n,
    output logic              par_q,
    output logic              err_n
);

    layout_e           layout;
    logic [W_WIDE-1:0] map_a;
    logic [W_PAIR-1:0] map_b;
    logic              gate_open;

    assign gate_open = !(sel_a_n && sel_b_n);

    rb_strap_latch u_straps (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_pair (cfg_pair),
        .cfg_alt  (cfg_alt),
        .layout   (layout)
    );

    rb_lane_map #(
        .W_WIDE (W_WIDE),
        .W_PAIR (W_PAIR)
    ) u_map (
        .layout (layout),
        .d      (d),
        .map_a  (map_a),
        .map_b  (map_b)
    );

    rb_parity_chk #(
        .ERR_HOLD (ERR_HOLD)
    ) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (gate_open),
        .cap_par (^map_a),
        .par_d   (par_d),
        .par_q   (par_q),
        .err_n   (err_n)
    );

    // gated data stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_a <= '0;
            q_b <= '0;
        end else if (gate_open) begin
            q_a <= map_a;
            q_b <= map_b;
        end
    end

    // ungated control stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q  <= 1'b0;
            odt_q  <= 1'b0;
            cs_q_n <= 1'b0;
        end else begin
            cke_q  <= cke_d;
            odt_q  <= odt_d;
            cs_q_n <= sel_a_n;
        end
    end

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n && sel_b_n) |=> ($stable(q_a) && $stable(q_b))) // R2
        else $error("data outputs moved while gated");

    AST_CTRL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_q == $past(cke_d) && odt_q == $past(odt_d) && cs_q_n == $past(sel_a_n))) // R4
        else $error("control stage did not follow its inputs");

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cke_q && !odt_q && !cs_q_n && !par_q && !err_n)) // R5
        else $error("output high during reset");

endmodule

// File: tb/test_cmd_addr_regbuf.sv
`timescale 1ns/1ps
module test_cmd_addr_regbuf;

    localparam int WW = 25;
    localparam int PW = 14;

    typedef struct {
        logic [WW-1:0] qa;
        logic [PW-1:0] qb;
        logic          cke;
        logic          odt;
        logic          cs;
        logic          pq;
        logic          en;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [WW-1:0] d = '0;
    logic          sel_a_n = 1'b1, sel_b_n = 1'b1, cke_d = 1'b0, odt_d = 1'b0, par_d = 1'b0;
    logic          cfg_pair = 1'b0, cfg_alt = 1'b0;
    logic [WW-1:0] q_a;
    logic [PW-1:0] q_b;
    logic          cke_q, odt_q, cs_q_n, par_q, err_n;

    int n_run = 0;
    int n_fail = 0;
    item_t sb[$];

    // bench reference state
    int            lay_m;     // 0 wide, 1 pair A, 2 pair B
    logic [WW-1:0] qa_m;
    logic [PW-1:0] qb_m;
    logic          cke_m, odt_m, cs_m, pq_m, pend_m, dpar_m, prev_ap;
    int            errc_m;

    always #10 clk = ~clk;

    cmd_addr_regbuf i_cmd_addr_regbuf (
        .clk(clk), .rst_n(rst_n), .d(d), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .cke_d(cke_d), .odt_d(odt_d), .par_d(par_d), .cfg_pair(cfg_pair), .cfg_alt(cfg_alt),
        .q_a(q_a), .q_b(q_b), .cke_q(cke_q), .odt_q(odt_q), .cs_q_n(cs_q_n),
        .par_q(par_q), .err_n(err_n)
    );

    function automatic logic [WW-1:0] exp_a(input int lay, input logic [WW-1:0] x);
        if (lay == 0) return x;
        if (lay == 1) return {11'b0, x[13:0]};
        return {11'b0, x[24:11]};
    endfunction

    function automatic logic [PW-1:0] exp_b(input int lay, input logic [WW-1:0] x);
        if (lay == 0) return '0;
        if (lay == 1) return x[13:0];
        return x[24:11];
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: called at a falling edge, applies inputs for the next rising edge
    task automatic step(input logic [WW-1:0] dv, input logic an, input logic bn,
                        input logic ck, input logic od, input logic flip, input string tag);
        item_t it;
        logic  mis;
        d = dv; sel_a_n = an; sel_b_n = bn; cke_d = ck; odt_d = od;
        par_d = prev_ap ^ flip;
        if (pend_m) begin
            mis  = dpar_m ^ par_d;
            pq_m = mis;
            if (mis) errc_m = 2;
            else if (errc_m > 0) errc_m--;
        end else if (errc_m > 0) errc_m--;
        if (!(an && bn)) begin
            qa_m = exp_a(lay_m, dv);
            qb_m = exp_b(lay_m, dv);
            dpar_m = ^qa_m;
            pend_m = 1'b1;
        end else pend_m = 1'b0;
        prev_ap = ^exp_a(lay_m, dv);
        cke_m = ck; odt_m = od; cs_m = an;
        it.qa = qa_m; it.qb = qb_m; it.cke = cke_m; it.odt = odt_m; it.cs = cs_m;
        it.pq = pq_m; it.en = (errc_m == 0); it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor: compares a quarter cycle after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, "q_a", 64'(q_a), 64'(it.qa));
                check(it.tag, "q_b", 64'(q_b), 64'(it.qb));
                check(it.tag, "ctrl", 64'({cke_q, odt_q, cs_q_n}), 64'({it.cke, it.odt, it.cs}));
                check(it.tag, "par_q", 64'(par_q), 64'(it.pq));
                check(it.tag, "err_n", 64'(err_n), 64'(it.en));
            end
        end
    end

    task automatic do_reset(input logic pair, input logic alt, input int lay);
        wait (sb.size() == 0);
        @(negedge clk);
        cfg_pair = pair; cfg_alt = alt;
        #3 rst_n = 1'b0;
        #1;
        // R5: cleared at once, with no clock edge in between
        check("R5", "async clear", 64'({q_a, q_b, cke_q, odt_q, cs_q_n, par_q, err_n}), 64'(0));
        qa_m = '0; qb_m = '0; cke_m = 0; odt_m = 0; cs_m = 0; pq_m = 0;
        pend_m = 0; dpar_m = 0; prev_ap = 0; errc_m = 0; lay_m = lay;
        repeat (2) @(negedge clk);
        check("R5", "held in reset", 64'({q_a, q_b, err_n}), 64'(0));
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // wide layout
        do_reset(1'b0, 1'b0, 0);
        step(25'h1ABCDEF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 6; i++)
            step(WW'($urandom), 1'b0, 1'b1, i[0], i[1], 1'b0, "R1");
        step(25'h0F0F0F0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        step(25'h1555555, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
        step(25'h0000001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        step(25'h0000003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        step(25'h0000007, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        step(25'h000000F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        step(25'h000001F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        // gated: data held, controls follow, no check after a closed edge
        step(25'h1FFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(25'h0123456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R12");
        step(25'h0654321, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
        step(25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R12");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        // sel_b tied low: plain register
        for (int i = 0; i < 4; i++)
            step(WW'($urandom), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

        // paired layout A
        do_reset(1'b1, 1'b0, 1);
        for (int i = 0; i < 5; i++)
            step(WW'($urandom), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(25'h1FFC000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R13");
        cfg_alt = 1'b1; cfg_pair = 1'b1;
        step(25'h1555555, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        cfg_pair = 1'b0;
        step(25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(25'h1234567, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

        // paired layout B
        do_reset(1'b1, 1'b1, 2);
        step(25'h1FFF800, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 5; i++)
            step(WW'($urandom), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(25'h00007FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R13");
        step(25'h0000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R12");

        // back to wide for a final reset-entry check
        do_reset(1'b0, 1'b0, 0);
        step(25'h1000001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        wait (sb.size() == 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule